// File: doc/BRIEF.md
# PWM Carrier Chopper with Leading Wide Pulse

This block sits after a PWM generator and reshapes each active-high period of a single PWM signal for transformer-coupled gate drivers. When chopping is on, every rising edge of the PWM input starts one wide pulse of programmable length. After that pulse ends, the output is a high-frequency carrier for the rest of the high period. When chopping is off, the PWM signal passes through after one register stage.

The carrier is derived from the system clock divided by eight. A divide code stretches it further. Each carrier period is split into eight equal slices, and the duty code picks how many of those slices are high. The carrier phase restarts on every rising PWM edge, so the chopped pattern is the same in every PWM period. A 16-bit control word holds all settings. A new value is written at once but only takes effect at the next carrier period boundary, so a running period is never cut short.

Top module: `pwm_chopper`

## Requirements
- R1: The control word resets to 0 and reads back with bits 15..11 as zero. Its fields are: duty code in bits 10..8, divide code in bits 7..5, wide-pulse code in bits 4..1, enable in bit 0.
- R2: With enable at 0, `chop_out` equals the value `pwm_in` had at the previous clock edge.
- R3: With enable at 1, a rising edge of `pwm_in` holds `chop_out` high for 8*(w+1) clocks, where w is the wide-pulse code. The first of these clocks is the cycle just after the rising edge is sampled. This holds while `pwm_in` stays high.
- R4: The carrier period is 8*(f+1) clocks, where f is the divide code. Its phase is zero in the first output cycle after a rising PWM edge.
- R5: Within each carrier period the carrier is high for the first (d+1)*(f+1) clocks, where d is the duty code. Duty code 7 behaves as duty code 3. Once the wide pulse has ended, the output is the carrier while `pwm_in` is high.
- R6: One clock after `pwm_in` is sampled low, `chop_out` is 0. A wide pulse cut short by a falling edge is cancelled, and the next rising edge starts a full-length one.
- R7: A written control word becomes active only at a carrier period boundary (phase wrap) or on a rising PWM edge. Until then the previous settings stay in force.
- R8: After reset `chop_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM signal to be chopped |
| chop_out | output | 1 | Chopped or bypassed PWM output |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback |

## Verification
The assertions assume that `pwm_in` is synchronous to `clk` and changes only between edges. They also assume that the active settings change only on a period wrap or a rising edge. The bench drives `pwm_in` and the write port only on falling clock edges. Before each PWM period it holds the input low for longer than the largest carrier period, so that a freshly written word is active. Only the boundary test writes while a period is running, and it predicts the exact wrap cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;
    localparam int REG_W   = 16;
    localparam int DUTY_W  = 3;
    localparam int FREQ_W  = 3;
    localparam int OS_W    = 4;
    localparam int SLICE_W = 3;                       // eight slices per period
    localparam int CFG_W   = DUTY_W + FREQ_W + OS_W + 1;
    localparam int RSV_W   = REG_W - CFG_W;
    localparam int PH_W    = FREQ_W + SLICE_W;        // phase within a period
    localparam int LIM_W   = PH_W + 1;
    localparam int OSC_W   = OS_W + 1 + SLICE_W;      // wide-pulse counter

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic [FREQ_W-1:0] freq;
        logic [OS_W-1:0]   width;
        logic              en;
    } chop_cfg_t;
endpackage

// File: rtl/chop_regs.sv
module chop_regs
    import chop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             load,
    output chop_cfg_t        act_q,
    output chop_cfg_t        act_d,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        chop_cfg_t prog;
        chop_cfg_t act;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.prog = chop_cfg_t'(wdata[CFG_W-1:0]);
        if (load) st_d.act = st_q.prog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_q = st_q.act;
    assign act_d = st_d.act;
    assign rdata = {{RSV_W{1'b0}}, st_q.prog};

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.act));
endmodule

// File: rtl/chop_carrier.sv
module chop_carrier
    import chop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  chop_cfg_t cfg_cur,
    input  chop_cfg_t cfg_nxt,
    output logic      wrap,
    output logic      car_hi_d
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } car_st_t;

    car_st_t st_d, st_q;
    logic [PH_W-1:0]   last_ph;
    logic [DUTY_W-1:0] dcode;
    logic [LIM_W-1:0]  lim;

    always_comb begin
        last_ph = {cfg_cur.freq, {SLICE_W{1'b1}}};
        wrap    = (st_q.ph == last_ph);
        st_d    = st_q;
        if (restart || wrap) st_d.ph = '0;
        else                 st_d.ph = st_q.ph + 1'b1;
        dcode    = (cfg_nxt.duty == {DUTY_W{1'b1}}) ? DUTY_W'(3) : cfg_nxt.duty;
        lim      = (LIM_W'(dcode) + LIM_W'(1)) * (LIM_W'(cfg_nxt.freq) + LIM_W'(1));
        car_hi_d = ({1'b0, st_d.ph} < lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= {cfg_cur.freq, {SLICE_W{1'b1}}});
endmodule

// File: rtl/chop_oneshot.sv
module chop_oneshot
    import chop_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm,
    input  logic            rise,
    input  logic [OS_W-1:0] width,
    output logic            busy_d
);
    typedef struct packed {
        logic [OSC_W-1:0] cnt;
        logic             pwm;
    } os_st_t;

    os_st_t st_d, st_q;
    logic [OS_W:0] units;

    always_comb begin
        units    = {1'b0, width} + 1'b1;
        st_d     = st_q;
        st_d.pwm = pwm;
        if (!pwm)                st_d.cnt = '0;
        else if (rise)           st_d.cnt = {units, {SLICE_W{1'b0}}};
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        busy_d = (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    os_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> st_q.pwm);
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
    import chop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    output logic             chop_out,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    typedef struct packed {
        logic pwm;
        logic out;
    } top_st_t;

    top_st_t   st_d, st_q;
    chop_cfg_t act_q, act_d;
    logic      rise, wrap, car_hi_d, os_busy_d;

    assign rise = pwm_in & ~st_q.pwm;

    chop_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .load(rise | wrap), .act_q(act_q), .act_d(act_d), .rdata(reg_rdata)
    );

    chop_carrier u_car (
        .clk(clk), .rst_n(rst_n), .restart(rise), .cfg_cur(act_q),
        .cfg_nxt(act_d), .wrap(wrap), .car_hi_d(car_hi_d)
    );

    chop_oneshot u_os (
        .clk(clk), .rst_n(rst_n), .pwm(pwm_in), .rise(rise),
        .width(act_d.width), .busy_d(os_busy_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pwm = pwm_in;
        if (act_d.en) st_d.out = pwm_in & (os_busy_d | car_hi_d);
        else          st_d.out = pwm_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chop_out = st_q.out;

    // R2
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q.en |-> (chop_out == st_q.pwm));
    // R6
    low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pwm |-> !chop_out);
    // R3
    rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && act_d.en) |=> chop_out);
    // R8
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> !chop_out);
endmodule

// File: tb/sim_pwm_chopper.sv
module sim_pwm_chopper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        chop_out;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_chopper u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .chop_out(chop_out),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] cfg_word(int d, int f, int w, int en);
        return 16'((d << 8) | (f << 5) | (w << 1) | en);
    endfunction

    function automatic logic exp_out(int t, int wlen, int per, int hi);
        return (t < wlen) || ((t % per) < hi);
    endfunction

    task automatic write_reg(input logic [15:0] v);
        reg_we = 1'b1; reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    // one PWM high period of len cycles, checked cycle by cycle, then low check
    task automatic run_high(input int len, input int wlen, input int per, input int hi,
                            input string req);
        pwm_in = 1'b1;
        for (int t = 0; t < len; t++) begin
            @(posedge clk); @(negedge clk);
            check(req, {15'b0, chop_out}, {15'b0, exp_out(t, wlen, per, hi)});
        end
        pwm_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R6 low after fall", {15'b0, chop_out}, 16'd0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        check("R8 out in reset", {15'b0, chop_out}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", reg_rdata, 16'h0000);
        check("R8 out after reset", {15'b0, chop_out}, 16'd0);

        write_reg(16'hFFFF);
        check("R1 reserved read zero", reg_rdata, 16'h07FF);
        write_reg(16'h0000);
        idle(70);

        // R2 bypass: output tracks input with one clock delay
        for (int i = 0; i < 40; i++) begin
            logic v;
            v = ((i % 3) == 0) || ((i % 7) == 2);
            pwm_in = v;
            @(posedge clk); @(negedge clk);
            check("R2 bypass", {15'b0, chop_out}, {15'b0, v});
        end
        pwm_in = 1'b0;

        // R3 R4 R5 sweep of every divide and duty code, all wide-pulse codes covered
        for (int f = 0; f < 8; f++) begin
            for (int d = 0; d < 8; d++) begin
                int w, per, hi, wlen, dc;
                w    = (f * 3 + d) % 16;
                dc   = (d == 7) ? 3 : d;
                per  = 8 * (f + 1);
                hi   = (dc + 1) * (f + 1);
                wlen = 8 * (w + 1);
                write_reg(cfg_word(d, f, w, 1));
                idle(70);
                run_high(wlen + 2 * per + 3, wlen, per, hi, "R3/R4/R5 sweep");
            end
        end

        // R6 fall cuts the wide pulse, next rise restarts it in full
        write_reg(cfg_word(2, 1, 15, 1));
        idle(70);
        run_high(20, 128, 16, 6, "R6 cut pulse");
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
            check("R6 stays low", {15'b0, chop_out}, 16'd0);
        end
        run_high(128 + 40, 128, 16, 6, "R6 full restart");

        // R7 write during a period lands at the next wrap
        write_reg(cfg_word(0, 7, 0, 0));
        idle(70);
        pwm_in = 1'b1;
        for (int t = 0; t <= 100; t++) begin
            @(posedge clk); @(negedge clk);
            check("R7 boundary", {15'b0, chop_out},
                  {15'b0, (t < 72) || (t >= 128)});
            if (t == 10) begin reg_we = 1'b1; reg_wdata = cfg_word(0, 7, 0, 1); end
            if (t == 11) reg_we = 1'b0;
        end
        pwm_in = 1'b0;
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule